// File: doc/BRIEF.md
# PHY LDO enable sequencer

This block owns the power-control words of three analog interface channels and steps them through ordered power-on and power-off write sequences. One channel is a display-serial link, one is a video-output port and one is a USB-style power gate. A client pulses a power-on or power-off request together with a channel-type code. The sequencer then applies one register write per clock, in the order that channel's analog front end requires. When the last write lands, it raises a single-cycle completion pulse.

The serial channel always turns on its control logic before its high-power LDO, and on the way down it drops back to control-only before clearing everything. The video-output channel holds its output reset driven while control is enabled and the LDO power-down is released. It then waits a programmable settle time, given in clock cycles, before it lets the reset go. Power-off on that channel puts the LDO into power-down before removing control enable. The USB-style gate needs a single write in either direction.

All sequences run on one engine, so only one channel is stepped at a time. A request that arrives while a sequence is running, or in the cycle its completion pulse is high, is dropped.

Top module: `phy_ldo_seq`

## Requirements
- R1: Out of reset the serial word is 0x0, the video word is 0x2 (LDO power-down, bit 1, set), the USB word is 0x0 and done_o is low.
- R2: Serial power-on (kind_i = 0) writes 0x1 (control enable, bit 0) on the accepting edge and 0x5 (adding high-power LDO enable, bit 2) on the next edge.
- R3: Serial power-off writes 0x1 on the accepting edge and 0x0 on the next edge.
- R4: Video power-on (kind_i = 1) does read-modify-write steps one edge apart: set reset-drive bit 19, then set bit 0, then clear bit 1, leaving all other bits as they were.
- R5: After the video power-down bit is cleared, bit 19 is cleared exactly SETTLE_CYC clock edges later, and no write happens in between.
- R6: Video power-off sets bit 1 on the accepting edge, then clears bit 0 on the next edge, leaving bit 19 and the other bits unchanged.
- R7: USB-style power-on (kind_i = 2) writes 0x1 and power-off writes 0x0, each in a single step on the accepting edge.
- R8: done_o is high for exactly the one cycle that follows the edge applying a sequence's final write.
- R9: Requests that arrive while a sequence is running, or in the cycle done_o is high, are ignored. They change no register and produce no extra done_o, whatever kind_i shows.
- R10: When on_req_i and off_req_i are both high at an accepting edge, the power-on sequence runs.
- R11: A sequence changes only the word of the channel it was started for.
- R12: A request with kind_i = 3 is ignored: no register changes and done_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| on_req_i | input | 1 | Power-on request, sampled when idle |
| off_req_i | input | 1 | Power-off request, sampled when idle |
| kind_i | input | 2 | Channel select: 0 serial, 1 video, 2 USB gate, 3 none |
| ser_reg_o | output | REG_W | Serial-channel power word |
| vid_reg_o | output | REG_W | Video-channel power word |
| usb_reg_o | output | REG_W | USB-gate power word |
| done_o | output | 1 | One-cycle pulse after the final write |

## Verification
The bench goes after the ordering on the video channel. A design that cleared the LDO power-down before control enable, or released the reset one cycle early or late, shows a wrong word at that exact negedge. Random requests and random kind codes are driven throughout every running sequence and during the done cycle. An engine that re-latched the kind, or accepted early, then writes into another channel or repeats the done pulse. Directed cases cover both requests high at once, which a design without on-priority would turn into a power-off, and the unused kind code, which a sloppy decoder would map onto a real channel.

// File: rtl/phy_ldo_pkg.sv
package phy_ldo_pkg;
  localparam int N_CH     = 3;
  localparam int CEN_BIT  = 0;   // control enable
  localparam int PD_BIT   = 1;   // video LDO power-down
  localparam int HP_BIT   = 2;   // serial high-power LDO enable
  localparam int RDRV_BIT = 19;  // video reset drive

  typedef enum logic [1:0] {
    K_SER  = 2'd0,
    K_VID  = 2'd1,
    K_USB  = 2'd2,
    K_NONE = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STEP = 2'd1,
    ST_WAIT = 2'd2
  } state_e;
endpackage

// File: rtl/phy_ldo_step_gen.sv
module phy_ldo_step_gen
  import phy_ldo_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic [1:0]       kind_i,
  input  logic             on_i,
  input  logic [1:0]       idx_i,
  input  logic [REG_W-1:0] cur_i,
  output logic [REG_W-1:0] nxt_o,
  output logic             last_o,
  output logic             wait_o
);
  localparam logic [REG_W-1:0] ONE    = {{(REG_W-1){1'b0}}, 1'b1};
  localparam logic [REG_W-1:0] M_CEN  = ONE << CEN_BIT;
  localparam logic [REG_W-1:0] M_PD   = ONE << PD_BIT;
  localparam logic [REG_W-1:0] M_HP   = ONE << HP_BIT;
  localparam logic [REG_W-1:0] M_RDRV = ONE << RDRV_BIT;

  always_comb begin
    nxt_o  = cur_i;
    last_o = 1'b0;
    wait_o = 1'b0;
    case (kind_i)
      K_SER: begin
        if (idx_i == 2'd0) begin
          nxt_o = M_CEN;
        end else begin
          nxt_o  = on_i ? (M_CEN | M_HP) : '0;
          last_o = 1'b1;
        end
      end
      K_VID: begin
        if (on_i) begin
          case (idx_i)
            2'd0: nxt_o = cur_i | M_RDRV;
            2'd1: nxt_o = cur_i | M_CEN;
            2'd2: begin
              nxt_o  = cur_i & ~M_PD;
              wait_o = 1'b1;
            end
            default: begin
              nxt_o  = cur_i & ~M_RDRV;
              last_o = 1'b1;
            end
          endcase
        end else if (idx_i == 2'd0) begin
          nxt_o = cur_i | M_PD;
        end else begin
          nxt_o  = cur_i & ~M_CEN;
          last_o = 1'b1;
        end
      end
      K_USB: begin
        nxt_o  = on_i ? M_CEN : '0;
        last_o = 1'b1;
      end
      default: last_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/phy_ldo_settle_tmr.sv
module phy_ldo_settle_tmr #(
  parameter int SETTLE_CYC = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic zero_o
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LOAD_V = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= LOAD_V;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/phy_ldo_chan_bank.sv
module phy_ldo_chan_bank
  import phy_ldo_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [1:0]             sel_i,
  input  logic [REG_W-1:0]       wdata_i,
  output logic [REG_W-1:0]       rd_o,
  output logic [N_CH*REG_W-1:0]  regs_o
);
  localparam logic [REG_W-1:0] ONE = {{(REG_W-1){1'b0}}, 1'b1};

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam logic [REG_W-1:0] RST_V = (c == int'(K_VID)) ? (ONE << PD_BIT) : '0;
    logic [REG_W-1:0] q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        q <= RST_V;
      else if (we_i && sel_i == 2'(c))    q <= wdata_i;
    end

    assign regs_o[c*REG_W +: REG_W] = q;
  end

  always_comb begin
    case (sel_i)
      K_SER:   rd_o = regs_o[0*REG_W +: REG_W];
      K_VID:   rd_o = regs_o[1*REG_W +: REG_W];
      K_USB:   rd_o = regs_o[2*REG_W +: REG_W];
      default: rd_o = '0;
    endcase
  end
endmodule

// File: rtl/phy_ldo_seq.sv
module phy_ldo_seq
  import phy_ldo_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int SETTLE_CYC = 5000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             on_req_i,
  input  logic             off_req_i,
  input  logic [1:0]       kind_i,
  output logic [REG_W-1:0] ser_reg_o,
  output logic [REG_W-1:0] vid_reg_o,
  output logic [REG_W-1:0] usb_reg_o,
  output logic             done_o
);
  state_e           state_q;
  logic [1:0]       kind_q, idx_q, sel_kind;
  logic             on_q, sel_on, done_q;
  logic             accept, we, last, wait_after, tmr_zero;
  logic [REG_W-1:0] cur, nxt;
  logic [N_CH*REG_W-1:0] regs;

  // idle edge samples the request; done cycle is a mandatory gap
  assign accept   = (state_q == ST_IDLE) && !done_q && (on_req_i || off_req_i) &&
                    (kind_i != K_NONE);
  assign sel_kind = (state_q == ST_IDLE) ? kind_i : kind_q;
  assign sel_on   = (state_q == ST_IDLE) ? on_req_i : on_q;
  assign we       = accept || (state_q == ST_STEP) || (state_q == ST_WAIT && tmr_zero);

  phy_ldo_step_gen #(.REG_W(REG_W)) u_step (
    .kind_i (sel_kind),
    .on_i   (sel_on),
    .idx_i  (idx_q),
    .cur_i  (cur),
    .nxt_o  (nxt),
    .last_o (last),
    .wait_o (wait_after)
  );

  phy_ldo_chan_bank #(.REG_W(REG_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .sel_i   (sel_kind),
    .wdata_i (nxt),
    .rd_o    (cur),
    .regs_o  (regs)
  );

  phy_ldo_settle_tmr #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (we && wait_after),
    .zero_o (tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= K_SER;
      on_q    <= 1'b0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= we && last;
      if (accept) begin
        kind_q <= kind_i;
        on_q   <= on_req_i;
      end
      if (we) begin
        if (last) begin
          state_q <= ST_IDLE;
          idx_q   <= '0;
        end else begin
          state_q <= wait_after ? ST_WAIT : ST_STEP;
          idx_q   <= idx_q + 2'd1;
        end
      end
    end
  end

  assign ser_reg_o = regs[0*REG_W +: REG_W];
  assign vid_reg_o = regs[1*REG_W +: REG_W];
  assign usb_reg_o = regs[2*REG_W +: REG_W];
  assign done_o    = done_q;
endmodule

// File: rtl/phy_ldo_seq_chk.sv
module phy_ldo_seq_chk
  import phy_ldo_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int SETTLE_CYC = 5000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [REG_W-1:0] ser_reg_o,
  input logic [REG_W-1:0] vid_reg_o,
  input logic [REG_W-1:0] usb_reg_o,
  input logic             done_o
);
  localparam int SW = $clog2(SETTLE_CYC + 1) + 1;
  localparam logic [SW-1:0] SAT = SW'(SETTLE_CYC);

  logic             pd_d;
  logic [SW-1:0]    since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_d    <= 1'b1;
      since_q <= '0;
    end else begin
      pd_d <= vid_reg_o[PD_BIT];
      if (pd_d && !vid_reg_o[PD_BIT]) since_q <= SW'(1);
      else if (since_q != '0 && since_q < SAT) since_q <= since_q + 1'b1;
    end
  end

  // R8: single-cycle done pulse
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R2: high-power LDO never on without control enable
  a_r2_hp_needs_cen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_reg_o[HP_BIT] |-> ser_reg_o[CEN_BIT]);

  // R4: control enable rises only while reset is driven
  a_r4_cen_under_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vid_reg_o[CEN_BIT]) |-> vid_reg_o[RDRV_BIT]);

  // R4: LDO released only with control enable and reset already up
  a_r4_pd_release_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vid_reg_o[PD_BIT]) |-> (vid_reg_o[CEN_BIT] && vid_reg_o[RDRV_BIT]));

  // R5: reset released no sooner than the settle time
  a_r5_settle_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vid_reg_o[RDRV_BIT]) |-> (since_q >= SAT));

  // R6: control enable drops only with LDO already powered down
  a_r6_off_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vid_reg_o[CEN_BIT]) |-> vid_reg_o[PD_BIT]);

  // R7: USB gate word only 0 or 1
  a_r7_usb_values: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usb_reg_o[REG_W-1:1] == '0);

  // R11: at most one channel word changes per cycle
  a_r11_one_channel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ser_reg_o != $past(ser_reg_o), vid_reg_o != $past(vid_reg_o),
              usb_reg_o != $past(usb_reg_o)}));
endmodule

bind phy_ldo_seq phy_ldo_seq_chk #(.REG_W(REG_W), .SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ser_reg_o (ser_reg_o),
  .vid_reg_o (vid_reg_o),
  .usb_reg_o (usb_reg_o),
  .done_o    (done_o)
);

// File: tb/phy_ldo_seq_test.sv
module phy_ldo_seq_test;
  localparam int REG_W  = 32;
  localparam int SETTLE = 9;
  localparam logic [31:0] CEN = 32'h1, PD = 32'h2, HP = 32'h4, RDRV = 32'h8_0000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic on_req_i = 1'b0, off_req_i = 1'b0;
  logic [1:0] kind_i = 2'd0;
  logic [REG_W-1:0] ser_reg_o, vid_reg_o, usb_reg_o;
  logic done_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m [3];

  phy_ldo_seq #(.REG_W(REG_W), .SETTLE_CYC(SETTLE)) uut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_next(int k, bit on, int idx, logic [31:0] cur);
    case (k)
      0: return (idx == 0) ? CEN : (on ? (CEN | HP) : 32'h0);
      1: if (on) begin
           case (idx)
             0: return cur | RDRV;
             1: return cur | CEN;
             2: return cur & ~PD;
             default: return cur & ~RDRV;
           endcase
         end else return (idx == 0) ? (cur | PD) : (cur & ~CEN);
      default: return on ? CEN : 32'h0;
    endcase
  endfunction

  function automatic int n_steps(int k, bit on);
    if (k == 0) return 2;
    if (k == 1) return on ? 4 : 2;
    return 1;
  endfunction

  function automatic string tag_of(int k, bit on, int s);
    if (k == 0) return on ? "R2" : "R3";
    if (k == 1) return on ? ((s == 3) ? "R5" : "R4") : "R6";
    return "R7";
  endfunction

  task automatic drive(bit noise);
    on_req_i  = noise ? 1'($urandom) : 1'b0;
    off_req_i = noise ? 1'($urandom) : 1'b0;
    kind_i    = noise ? 2'($urandom) : 2'd0;
  endtask

  task automatic chk_regs(string tag, bit dn);
    chk(tag, {ser_reg_o, vid_reg_o, usb_reg_o, 31'd0, done_o},
             {m[0], m[1], m[2], 31'd0, dn});
  endtask

  task automatic run_seq(bit on, bit off, int k, bit noise);
    bit eff_on;
    int ns;
    @(negedge clk_i);
    on_req_i = on; off_req_i = off; kind_i = 2'(k);
    if (k == 3 || (!on && !off)) begin
      @(negedge clk_i);
      chk_regs("R12", 1'b0);
      drive(1'b0);
      return;
    end
    eff_on = on;  // R10: on wins
    ns = n_steps(k, eff_on);
    for (int s = 0; s < ns; s++) begin
      if (k == 1 && eff_on && s == 3) begin
        for (int w = 1; w < SETTLE; w++) begin
          @(negedge clk_i);
          chk_regs("R5", 1'b0);
          drive(noise);
        end
      end
      m[k] = exp_next(k, eff_on, s, m[k]);
      @(negedge clk_i);
      chk_regs(tag_of(k, eff_on, s), s == ns - 1);
      chk("R11", {ser_reg_o, vid_reg_o, usb_reg_o}, {m[0], m[1], m[2]});
      drive(noise);
    end
    @(negedge clk_i);
    chk_regs(noise ? "R9" : "R8", 1'b0);
    drive(1'b0);
  endtask

  initial begin
    void'($urandom(32'd4051));
    m[0] = 32'h0; m[1] = PD; m[2] = 32'h0;
    repeat (3) @(negedge clk_i);
    chk_regs("R1", 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_regs("R1", 1'b0);

    run_seq(1, 0, 0, 0);   // R2
    run_seq(0, 1, 0, 0);   // R3
    run_seq(1, 0, 1, 0);   // R4 R5
    run_seq(0, 1, 1, 0);   // R6
    run_seq(1, 0, 2, 0);   // R7
    run_seq(0, 1, 2, 1);   // R7 with R9 noise
    run_seq(1, 1, 1, 0);   // R10
    run_seq(1, 1, 0, 1);   // R10
    run_seq(1, 0, 3, 0);   // R12
    run_seq(0, 1, 3, 0);   // R12

    for (int i = 0; i < 250; i++) begin
      int k = int'($urandom % 4);
      int p = int'($urandom % 4);
      run_seq(p[0], p[1], k, 1'b1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule